// File: doc/BRIEF.md
# Three-Wire Shutter Code Receiver

This block takes a manual exposure setting for a CCD camera's electronic shutter from three shared input pins and presents it as an 8-bit shutter code with a one-cycle change flag. The pins work in one of two ways. In serial form they carry data, a shift clock and a load strobe. Eight bits are shifted in, most significant first, and a strobe edge moves the shifted byte into the output register. In parallel form the three pin levels pick one of eight preset speeds, and each preset maps to a fixed code. The two slowest and fastest presets depend on the video standard.

All three pins are asynchronous to the system clock. They pass through a synchronizer and are edge-detected in the system clock domain. The system clock must therefore run at least three times faster than the shift clock. When iris mode is selected, the receiver ignores the pins completely and holds its last code.

Top module: `shutter_code_rx`

## Requirements
- R1: In serial mode (`iris_mode`=0, `par_sel`=0), each rising edge of `pin_sclk` shifts the level of `pin_data` into an 8-bit shift register, most significant bit first, so that the first of eight bits ends up in bit 7.
- R2: In serial mode, a rising edge of `pin_strobe` copies the shift register to `code_out`; the new code appears on the third rising system clock edge after the pin rises.
- R3: In serial mode, `code_out` does not change unless a strobe rising edge is seen, whatever the data and shift clock pins do.
- R4: A strobe is never blocked. If fewer than eight bits have been shifted since the last load, the register still loads: the newest bits sit in the low positions and the older bits move up. The shift register is not cleared by a load.
- R5: When the shift clock and the strobe rise in the same sampled cycle, the load takes the shift register contents from before that cycle's shift, and the new bit is still shifted in.
- R6: In parallel mode (`iris_mode`=0, `par_sel`=1), `code_out` follows the preset selected by index {~`pin_data`, ~`pin_sclk`, ~`pin_strobe`}. Indices 1 to 6 give the codes 0xC8, 0xAA, 0x8C, 0x6E, 0x50 and 0x32.
- R7: In parallel mode, index 0 (all pins high) gives 0xE6 when `std_pal`=0 and 0xDC when `std_pal`=1. Index 7 (all pins low) gives 0x05 when `std_pal`=0 and 0x0A when `std_pal`=1.
- R8: While `iris_mode`=1, `code_out` holds its value, no pin activity produces a `code_valid` pulse, and the shift register is left untouched.
- R9: `code_valid` is high for exactly the cycle in which `code_out` shows a new value. A load of a code equal to the current one gives no pulse.
- R10: After reset, `code_out` is 0x00, `code_valid` is 0 and the shift register holds 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_data | input | 1 | Serial data, or parallel select bit 2 (inverted) |
| pin_sclk | input | 1 | Serial shift clock, or parallel select bit 1 (inverted) |
| pin_strobe | input | 1 | Serial load strobe, or parallel select bit 0 (inverted) |
| iris_mode | input | 1 | 1 selects iris mode: all pins are ignored |
| par_sel | input | 1 | 0 selects serial input, 1 selects parallel presets |
| std_pal | input | 1 | 0 selects NTSC presets, 1 selects PAL presets |
| code_out | output | 8 | Active shutter code |
| code_valid | output | 1 | One-cycle pulse when `code_out` changes |

## Verification
The shift and the load can happen in the same cycle, when the shift clock and the strobe rise together. The bench provokes this by first shifting a full byte without any strobe, then raising both pins on the same system clock edge with data high. It checks that `code_out` takes the byte from before the shift. A later lone strobe must then show that byte moved up one place, with a 1 in bit 0.

// File: rtl/shr_pkg.sv
package shr_pkg;
   typedef enum logic [1:0] {
      MODE_IRIS   = 2'd0,
      MODE_SERIAL = 2'd1,
      MODE_PRESET = 2'd2
   } rx_mode_e;

   function automatic rx_mode_e decode_mode(input logic iris, input logic par);
      if (iris)     return MODE_IRIS;
      else if (par) return MODE_PRESET;
      else          return MODE_SERIAL;
   endfunction
endpackage

// File: rtl/shr_sync.sv
module shr_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("shr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/shr_serial.sv
module shr_serial #(
   parameter int  CODE_W    = 8,
   parameter bit  MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              dat_lvl,
   input  logic              sclk_lvl,
   input  logic              strb_lvl,
   output logic              strb_rise,
   output logic [CODE_W-1:0] shift_q
);
   logic sclk_prev, strb_prev, sclk_rise;
   logic [CODE_W-1:0] shift_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         strb_prev <= 1'b0;
      end else begin
         sclk_prev <= sclk_lvl;
         strb_prev <= strb_lvl;
      end
   end

   assign sclk_rise = sclk_lvl & ~sclk_prev;
   assign strb_rise = strb_lvl & ~strb_prev;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shift_nx = {shift_q[CODE_W-2:0], dat_lvl};
      end else begin : g_lsb
         assign shift_nx = {dat_lvl, shift_q[CODE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     shift_q <= '0;
      else if (shift_en && sclk_rise) shift_q <= shift_nx;
   end
endmodule

// File: rtl/shr_preset.sv
module shr_preset #(
   parameter int                  CODE_W   = 8,
   parameter logic [8*CODE_W-1:0] TBL_NTSC = '0,
   parameter logic [8*CODE_W-1:0] TBL_PAL  = '0
) (
   input  logic [2:0]        sel,
   input  logic              pal,
   output logic [CODE_W-1:0] code
);
   localparam int N_PRESET = 8;
   logic [CODE_W-1:0] ent_ntsc [N_PRESET];
   logic [CODE_W-1:0] ent_pal  [N_PRESET];

   generate
      for (genvar i = 0; i < N_PRESET; i++) begin : g_ent
         assign ent_ntsc[i] = TBL_NTSC[i*CODE_W +: CODE_W];
         assign ent_pal[i]  = TBL_PAL[i*CODE_W +: CODE_W];
      end
   endgenerate

   assign code = pal ? ent_pal[sel] : ent_ntsc[sel];
endmodule

// File: rtl/shutter_code_rx.sv
module shutter_code_rx #(
   parameter int                  CODE_W      = 8,
   parameter int                  SYNC_STAGES = 2,
   parameter bit                  MSB_FIRST   = 1'b1,
   parameter logic [CODE_W-1:0]   RESET_CODE  = '0,
   parameter logic [8*CODE_W-1:0] TBL_NTSC    = {8'h05, 8'h32, 8'h50, 8'h6E, 8'h8C, 8'hAA, 8'hC8, 8'hE6},
   parameter logic [8*CODE_W-1:0] TBL_PAL     = {8'h0A, 8'h32, 8'h50, 8'h6E, 8'h8C, 8'hAA, 8'hC8, 8'hDC}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_data,
   input  logic              pin_sclk,
   input  logic              pin_strobe,
   input  logic              iris_mode,
   input  logic              par_sel,
   input  logic              std_pal,
   output logic [CODE_W-1:0] code_out,
   output logic              code_valid
);
   import shr_pkg::*;

   generate
      if (CODE_W < 2) begin : g_bad_w
         $error("shutter_code_rx: CODE_W must be at least 2");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              strb_rise;
   logic [CODE_W-1:0] shift_q, preset_code, code_nx, code_q;
   logic              valid_q;
   rx_mode_e          mode;

   assign mode = decode_mode(iris_mode, par_sel);

   shr_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({pin_data, pin_sclk, pin_strobe}),
      .q(pins_s)
   );

   shr_serial #(.CODE_W(CODE_W), .MSB_FIRST(MSB_FIRST)) i_serial (
      .clk(clk), .rst_n(rst_n),
      .shift_en(mode == MODE_SERIAL),
      .dat_lvl(pins_s[2]), .sclk_lvl(pins_s[1]), .strb_lvl(pins_s[0]),
      .strb_rise(strb_rise),
      .shift_q(shift_q)
   );

   shr_preset #(.CODE_W(CODE_W), .TBL_NTSC(TBL_NTSC), .TBL_PAL(TBL_PAL)) i_preset (
      .sel(~pins_s), .pal(std_pal), .code(preset_code)
   );

   always_comb begin
      code_nx = code_q;
      unique case (mode)
         MODE_PRESET: code_nx = preset_code;
         MODE_SERIAL: if (strb_rise) code_nx = shift_q;
         default:     code_nx = code_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= RESET_CODE;
         valid_q <= 1'b0;
      end else begin
         code_q  <= code_nx;
         valid_q <= (code_nx != code_q);
      end
   end

   assign code_out   = code_q;
   assign code_valid = valid_q;
endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
   parameter int CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iris_mode,
   input logic              par_sel,
   input logic              strb_rise,
   input logic [CODE_W-1:0] code_out,
   input logic              code_valid
);
   // R9: every change of the code is flagged
   a_r9_valid_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (code_out != $past(code_out)) |-> code_valid);

   // R9: the flag never fires without a change
   a_r9_valid_only_change: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid |-> (code_out != $past(code_out)));

   // R8: iris mode holds the code
   a_r8_iris_hold: assert property (@(posedge clk) disable iff (!rst_n)
      iris_mode |=> $stable(code_out));

   // R3: serial mode only changes on a strobe edge
   a_r3_serial_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!iris_mode && !par_sel && !strb_rise) |=> $stable(code_out));
endmodule

bind shutter_code_rx shr_checker #(.CODE_W(CODE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .iris_mode(iris_mode), .par_sel(par_sel),
   .strb_rise(strb_rise), .code_out(code_out), .code_valid(code_valid)
);

// File: tb/test_shutter_code_rx.sv
module test_shutter_code_rx;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_data = 1'b0, pin_sclk = 1'b0, pin_strobe = 1'b0;
   logic iris_mode = 1'b0, par_sel = 1'b0, std_pal = 1'b0;
   logic [7:0] code_out;
   logic code_valid;
   int n_chk = 0, n_fail = 0, n_valid = 0;

   always #2 clk = ~clk;

   shutter_code_rx i_shutter_code_rx (
      .clk(clk), .rst_n(rst_n), .pin_data(pin_data), .pin_sclk(pin_sclk),
      .pin_strobe(pin_strobe), .iris_mode(iris_mode), .par_sel(par_sel),
      .std_pal(std_pal), .code_out(code_out), .code_valid(code_valid)
   );

   always @(posedge clk) if (rst_n && code_valid) n_valid++;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_sclk(input logic b);
      pin_data = b; cyc(2);
      pin_sclk = 1'b1; cyc(3);
      pin_sclk = 1'b0; cyc(3);
   endtask

   task automatic shift_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) pulse_sclk(v[i]);
   endtask

   task automatic strobe();
      pin_strobe = 1'b1; cyc(3);
      pin_strobe = 1'b0; cyc(4);
   endtask

   task automatic t_reset();
      cyc(1);
      check("R10 code", code_out, 8'h00);
      check("R10 valid", code_valid, 0);
      rst_n = 1'b1; cyc(3);
      strobe();
      check("R10 shift register zero", code_out, 8'h00);
      check("R10/R9 no pulse", n_valid, 0);
   endtask

   task automatic t_serial_byte(input logic [7:0] v);
      int v0 = n_valid;
      shift_byte(v);
      check("R3 no load before strobe", n_valid - v0, 0);
      pin_strobe = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      check("R2 not yet after 2 edges", n_valid - v0, 0);
      @(posedge clk); #1;
      check("R1/R2 code", code_out, v);
      check("R9 valid high", code_valid, 1);
      @(posedge clk); #1;
      check("R9 single cycle", code_valid, 0);
      cyc(2); pin_strobe = 1'b0; cyc(4);
      check("R9 one pulse", n_valid - v0, 1);
   endtask

   task automatic t_partial();
      shift_byte(8'h3C);
      strobe();
      pulse_sclk(1); pulse_sclk(0); pulse_sclk(1);
      strobe();
      check("R4 partial frame", code_out, 8'hE5);
   endtask

   task automatic t_same_code();
      int v0 = n_valid;
      strobe();
      check("R9 equal load code", code_out, 8'hE5);
      check("R9 equal load no pulse", n_valid - v0, 0);
   endtask

   task automatic t_coincide();
      shift_byte(8'h5A);
      check("R3 held without strobe", code_out, 8'hE5);
      pin_data = 1'b1; cyc(2);
      pin_sclk = 1'b1; pin_strobe = 1'b1; cyc(4);
      pin_sclk = 1'b0; pin_strobe = 1'b0; cyc(4);
      check("R5 load pre-shift value", code_out, 8'h5A);
      strobe();
      check("R5 bit still shifted", code_out, 8'hB5);
   endtask

   task automatic t_parallel();
      logic [7:0] exp_n [8] = '{8'hE6, 8'hC8, 8'hAA, 8'h8C, 8'h6E, 8'h50, 8'h32, 8'h05};
      par_sel = 1'b1;
      for (int i = 0; i < 8; i++) begin
         {pin_data, pin_sclk, pin_strobe} = ~3'(i);
         cyc(6);
         check((i == 0 || i == 7) ? "R7 NTSC preset" : "R6 preset", code_out, exp_n[i]);
      end
      std_pal = 1'b1; cyc(3);
      check("R7 PAL fastest", code_out, 8'h0A);
      {pin_data, pin_sclk, pin_strobe} = 3'b111; cyc(6);
      check("R7 PAL slowest", code_out, 8'hDC);
      {pin_data, pin_sclk, pin_strobe} = 3'b101; cyc(6);
      check("R6 PAL index 2", code_out, 8'hAA);
   endtask

   task automatic t_iris();
      int v0;
      iris_mode = 1'b1; cyc(3);
      v0 = n_valid;
      {pin_data, pin_sclk, pin_strobe} = 3'b000; cyc(4);
      par_sel = 1'b0; cyc(2);
      shift_byte(8'h11);
      strobe();
      check("R8 code held", code_out, 8'hAA);
      check("R8 no pulse", n_valid - v0, 0);
      iris_mode = 1'b0; cyc(4);
      strobe();
      check("R8 shift register untouched", code_out, 8'hB5);
   endtask

   initial begin
      t_reset();
      t_serial_byte(8'hA5);
      t_serial_byte(8'h3C);
      t_partial();
      t_same_code();
      t_coincide();
      t_parallel();
      t_iris();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule